// File: doc/BRIEF.md
# Segment Descriptor Load and Access Check

This block loads one segment register and then screens every data access made through it. A load request carries a 16-bit selector. The block decodes the selector and picks the global or the local descriptor table. It checks that the chosen slot lies inside that table, then fetches the 8-byte descriptor over a simple 32-bit read port as two word reads. It checks the present bit and the privilege rule, and caches the base, the 20-bit limit and the attribute bits in a shadow copy. Later accesses use only that copy and never read the table again.

Each access presents a 32-bit offset. The block scales the cached limit by the granularity bit and compares the offset against it. It returns the linear address together with a fault code. Loads report their own fault code on a one-cycle done pulse. A load that faults never issues a memory read.

Top module: `seg_load_check`

## Requirements
- R1: The selector is split as index = bits 15..3, table select = bit 2 (0 global, 1 local) and requested level = bits 1..0. The first descriptor read goes to the chosen table base plus index*8.
- R2: A selector whose index is 0 ends the load one cycle after the request with done and fault 2'b01, and issues no memory read.
- R3: When index*8+7 is greater than the chosen table's limit, the load ends one cycle after the request with fault 2'b01 and issues no memory read.
- R4: A load that passes the table checks reads the low descriptor word first and then the word at that address plus 4. `busy` is high from the cycle after the request until the done pulse, and `mem_req` is only high while `busy` is high.
- R5: Descriptor word 0 holds limit[15:0] in bits 15..0 and base[15:0] in bits 31..16. Word 1 holds base[23:16] in bits 7..0, the access byte {P, DPL[1:0], S, type[3:0]} in bits 15..8, limit[19:16] in bits 19..16, the flags {G, D, two spare bits} in bits 23..20, and base[31:24] in bits 31..24. After a good load, `seg_attr` shows {flags, access byte}.
- R6: A descriptor with P=0 ends the load with fault 2'b10 (not present), distinct from 2'b01. The code 2'b11 never appears.
- R7: When max(CPL, RPL) is greater than DPL, the load ends with fault 2'b01. CPL is the `cpl` input and RPL comes from the selector.
- R8: `shadow_valid` is 0 after reset and after any faulting load. While it is 0, every access reports fault 2'b01.
- R9: The effective limit is the 20-bit limit when G=0 and (limit<<12)|0xFFF when G=1. An offset equal to the effective limit passes, and an offset one above it reports fault 2'b01.
- R10: With a valid shadow and an offset within the limit, `acc_lin` equals the cached base plus the offset modulo 2^32, and `acc_fault` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | TLIM_W | Global table byte limit |
| ldt_base | input | 32 | Local table base (cached) |
| ldt_limit | input | TLIM_W | Local table byte limit (cached) |
| cpl | input | 2 | Current privilege level |
| load_req | input | 1 | Start a load, sampled while idle |
| load_sel | input | 16 | Selector to load |
| busy | output | 1 | Descriptor fetch in progress |
| load_done | output | 1 | One-cycle load completion pulse |
| load_fault | output | 2 | Load result: 00 none, 01 protection, 10 not present |
| mem_req | output | 1 | Read request, held until data returns |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| shadow_valid | output | 1 | Shadow copy holds a usable descriptor |
| seg_attr | output | 12 | Cached flags nibble and access byte |
| acc_off | input | 32 | Access offset |
| acc_lin | output | 32 | Linear address |
| acc_fault | output | 2 | Access result, same encoding as load_fault |

## Verification
Loads are exercised with selectors that hit each exit of the check chain: a null index, an index past the global table, an index past the local table, an absent descriptor, a requested level above DPL, a current level above DPL, and good descriptors in both tables. These cases show that each fault comes from the right rule, in the right priority, and that failed loads never touch memory. Accesses then probe offsets at the effective limit and one past it, for both byte and page granularity. They also use a base near the top of the address space, which separates correct limit scaling from raw comparison and shows that the addition wraps.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int AW    = 32;
    localparam int SEL_W = 16;
    localparam int LIM_W = 20;
    localparam int ATR_W = 12;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_GP   = 2'b01,
        FLT_NP   = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_RD_LO = 2'b01,
        ST_RD_HI = 2'b10
    } state_e;

    // attr = {G, D, spare, spare, P, DPL[1:0], S, type[3:0]}
    typedef struct packed {
        logic [AW-1:0]    base;
        logic [LIM_W-1:0] limit;
        logic [ATR_W-1:0] attr;
    } shadow_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_pkg::*;
#(
    parameter int TLIM_W = 16
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [AW-1:0]     gdt_base,
    input  logic [TLIM_W-1:0] gdt_limit,
    input  logic [AW-1:0]     ldt_base,
    input  logic [TLIM_W-1:0] ldt_limit,
    output logic              is_null,
    output logic              out_of_bounds,
    output logic [AW-1:0]     desc_addr,
    output logic [1:0]        rpl
);
    localparam int IDX_W = SEL_W - 3;

    logic [IDX_W-1:0]  idx;
    logic              use_local;
    logic [AW-1:0]     tbl_base;
    logic [TLIM_W-1:0] tbl_limit;
    logic [SEL_W-1:0]  last_byte;

    always_comb begin
        idx       = sel[SEL_W-1:3];
        use_local = sel[2];
        rpl       = sel[1:0];
        tbl_base  = use_local ? ldt_base  : gdt_base;
        tbl_limit = use_local ? ldt_limit : gdt_limit;
        // index*8 + 7: the low three bits become ones, no carry possible
        last_byte     = {idx, 3'b111};
        is_null       = (idx == '0);
        out_of_bounds = 32'(last_byte) > 32'(tbl_limit);
        desc_addr     = tbl_base + AW'({idx, 3'b000});
    end
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_pkg::*;
(
    input  logic [31:0] word_lo,
    input  logic [31:0] word_hi,
    output shadow_t     desc
);
    always_comb begin
        desc.base  = {word_hi[31:24], word_hi[7:0], word_lo[31:16]};
        desc.limit = {word_hi[19:16], word_lo[15:0]};
        desc.attr  = {word_hi[23:20], word_hi[15:8]};
    end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
    import seg_pkg::*;
(
    input  logic             valid,
    input  logic [AW-1:0]    base,
    input  logic [LIM_W-1:0] limit,
    input  logic             gran,
    input  logic [AW-1:0]    offset,
    output logic [AW-1:0]    linear,
    output fault_e           fault
);
    localparam int PG_SH = AW - LIM_W;

    logic [AW-1:0] eff_limit;

    always_comb begin
        if (gran) eff_limit = {limit, {PG_SH{1'b1}}};
        else      eff_limit = {{PG_SH{1'b0}}, limit};
        linear = base + offset;
        if (!valid || (offset > eff_limit)) fault = FLT_GP;
        else                                fault = FLT_NONE;
    end
endmodule

// File: rtl/seg_load_check.sv
module seg_load_check
    import seg_pkg::*;
#(
    parameter int TLIM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       gdt_base,
    input  logic [TLIM_W-1:0] gdt_limit,
    input  logic [31:0]       ldt_base,
    input  logic [TLIM_W-1:0] ldt_limit,
    input  logic [1:0]        cpl,
    input  logic              load_req,
    input  logic [15:0]       load_sel,
    output logic              busy,
    output logic              load_done,
    output logic [1:0]        load_fault,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              shadow_valid,
    output logic [11:0]       seg_attr,
    input  logic [31:0]       acc_off,
    output logic [31:0]       acc_lin,
    output logic [1:0]        acc_fault
);
    typedef struct packed {
        state_e      state;
        logic [31:0] addr;
        logic [31:0] lo;
        logic [1:0]  rpl;
        logic        done;
        fault_e      fault;
        logic        valid;
        shadow_t     sh;
    } regs_t;

    regs_t r_q, r_d;

    logic        sel_null, sel_oob;
    logic [31:0] sel_addr;
    logic [1:0]  sel_rpl;
    shadow_t     fetched;
    fault_e      acc_fault_e;
    logic [1:0]  eff_lvl;

    seg_sel_decode #(.TLIM_W(TLIM_W)) dec_i (
        .sel           (load_sel),
        .gdt_base      (gdt_base),
        .gdt_limit     (gdt_limit),
        .ldt_base      (ldt_base),
        .ldt_limit     (ldt_limit),
        .is_null       (sel_null),
        .out_of_bounds (sel_oob),
        .desc_addr     (sel_addr),
        .rpl           (sel_rpl)
    );

    seg_desc_unpack unp_i (
        .word_lo (r_q.lo),
        .word_hi (mem_rdata),
        .desc    (fetched)
    );

    seg_access_check acc_i (
        .valid  (r_q.valid),
        .base   (r_q.sh.base),
        .limit  (r_q.sh.limit),
        .gran   (r_q.sh.attr[11]),
        .offset (acc_off),
        .linear (acc_lin),
        .fault  (acc_fault_e)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        eff_lvl  = (cpl > r_q.rpl) ? cpl : r_q.rpl;
        unique case (r_q.state)
            ST_IDLE: begin
                if (load_req) begin
                    if (sel_null || sel_oob) begin
                        r_d.done  = 1'b1;
                        r_d.fault = FLT_GP;
                        r_d.valid = 1'b0;
                    end else begin
                        r_d.state = ST_RD_LO;
                        r_d.addr  = sel_addr;
                        r_d.rpl   = sel_rpl;
                    end
                end
            end
            ST_RD_LO: begin
                if (mem_rvalid) begin
                    r_d.lo    = mem_rdata;
                    r_d.state = ST_RD_HI;
                end
            end
            ST_RD_HI: begin
                if (mem_rvalid) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    if (!fetched.attr[7]) begin
                        r_d.fault = FLT_NP;
                        r_d.valid = 1'b0;
                    end else if (eff_lvl > fetched.attr[6:5]) begin
                        r_d.fault = FLT_GP;
                        r_d.valid = 1'b0;
                    end else begin
                        r_d.fault = FLT_NONE;
                        r_d.valid = 1'b1;
                        r_d.sh    = fetched;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.fault <= FLT_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.state != ST_IDLE);
    assign mem_req      = (r_q.state == ST_RD_LO) || (r_q.state == ST_RD_HI);
    assign mem_addr     = (r_q.state == ST_RD_HI) ? (r_q.addr + 32'd4) : r_q.addr;
    assign load_done    = r_q.done;
    assign load_fault   = r_q.fault;
    assign shadow_valid = r_q.valid;
    assign seg_attr     = r_q.sh.attr;
    assign acc_fault    = acc_fault_e;
endmodule

// File: rtl/seg_load_check_sva.sv
module seg_load_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        load_req,
    input logic [15:0] load_sel,
    input logic        busy,
    input logic        load_done,
    input logic [1:0]  load_fault,
    input logic        mem_req,
    input logic        mem_rvalid,
    input logic [31:0] mem_addr,
    input logic        shadow_valid,
    input logic [1:0]  acc_fault
);
    a_r4_req_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !busy);

    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> $stable(mem_addr));

    a_r2_null_fast_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !busy && (load_sel[15:3] == 13'd0)) |=>
            (load_done && load_fault == 2'b01 && !mem_req));

    a_r6_no_code_3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fault != 2'b11) && (acc_fault != 2'b11));

    a_r8_fault_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && load_fault != 2'b00) |-> !shadow_valid);

    a_r8_invalid_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
        !shadow_valid |-> (acc_fault == 2'b01));
endmodule

bind seg_load_check seg_load_check_sva chk_i (.*);

// File: tb/seg_load_check_tb_top.sv
module seg_load_check_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] gdt_base = 32'h100;
    logic [15:0] gdt_limit = 16'h002F;
    logic [31:0] ldt_base = 32'h200;
    logic [15:0] ldt_limit = 16'h000F;
    logic [1:0]  cpl = 2'd0;
    logic        load_req = 1'b0;
    logic [15:0] load_sel = 16'h0;
    logic        busy, load_done, mem_req, shadow_valid;
    logic [1:0]  load_fault, acc_fault;
    logic [31:0] mem_addr, acc_lin;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic [11:0] seg_attr;
    logic [31:0] acc_off = 32'h0;

    int checks = 0;
    int errors = 0;
    int n_xfer = 0;
    logic [31:0] xaddr [2];
    logic [31:0] mem_w [256];

    always #4 clk = ~clk;

    seg_load_check dut_i (.*);

    always @(posedge clk) begin
        mem_rvalid <= mem_req && !mem_rvalid;
        mem_rdata  <= mem_w[mem_addr[9:2]];
        if (mem_req && mem_rvalid) begin
            if (n_xfer < 2) xaddr[n_xfer] <= mem_addr;
            n_xfer <= n_xfer + 1;
        end
    end

    typedef struct packed {
        logic [15:0] sel;
        logic [1:0]  cpl;
        logic [31:0] off;
        logic [1:0]  nrd;
        logic [1:0]  lf;
        logic [1:0]  af;
        logic [31:0] lin;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'h0008, 2'd0, 32'h00000FFF, 2'd2, 2'b00, 2'b00, 32'h00010FFF},
        '{16'h0008, 2'd0, 32'h00001000, 2'd2, 2'b00, 2'b01, 32'h0},
        '{16'h0013, 2'd3, 32'h00003FFF, 2'd2, 2'b00, 2'b00, 32'h10003FFF},
        '{16'h0013, 2'd3, 32'h00004000, 2'd2, 2'b00, 2'b01, 32'h0},
        '{16'h0023, 2'd3, 32'h00002000, 2'd2, 2'b00, 2'b00, 32'h00001000},
        '{16'h000F, 2'd3, 32'h000000FF, 2'd2, 2'b00, 2'b00, 32'h020000FF},
        '{16'h001B, 2'd3, 32'h00000000, 2'd2, 2'b10, 2'b01, 32'h0},
        '{16'h002B, 2'd0, 32'h00000000, 2'd2, 2'b01, 2'b01, 32'h0},
        '{16'h0028, 2'd3, 32'h00000000, 2'd2, 2'b01, 2'b01, 32'h0},
        '{16'h0000, 2'd0, 32'h00000000, 2'd0, 2'b01, 2'b01, 32'h0},
        '{16'h0030, 2'd0, 32'h00000000, 2'd0, 2'b01, 2'b01, 32'h0},
        '{16'h0017, 2'd3, 32'h00000000, 2'd0, 2'b01, 2'b01, 32'h0},
        '{16'h0028, 2'd0, 32'h00000010, 2'd2, 2'b00, 2'b00, 32'h00005010}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] addr, input logic [31:0] base,
                            input logic [19:0] lim, input bit g, input bit p,
                            input logic [1:0] dpl);
        mem_w[addr[9:2]]       = {base[15:0], lim[15:0]};
        mem_w[addr[9:2] + 8'd1] = {base[31:24], g, 1'b1, 2'b00, lim[19:16],
                                  p, dpl, 1'b1, 4'b0010, base[23:16]};
    endtask

    task automatic do_load(input logic [15:0] sel, input logic [1:0] lvl,
                           input int nrd, input string req);
        @(negedge clk);
        n_xfer   = 0;
        cpl      = lvl;
        load_sel = sel;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        check(busy == (nrd != 0), "R4 busy after request", 32'(busy), 32'(nrd != 0));
        for (int i = 0; i < 40 && !load_done; i++) @(negedge clk);
        check(load_done == 1'b1, req, 32'(load_done), 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] exp_a;
        for (int i = 0; i < 256; i++) mem_w[i] = 32'h0;
        put_desc(32'h108, 32'h0001_0000, 20'h00FFF, 1'b0, 1'b1, 2'd0);
        put_desc(32'h110, 32'h1000_0000, 20'h00003, 1'b1, 1'b1, 2'd3);
        put_desc(32'h118, 32'h0300_0000, 20'h0FFFF, 1'b0, 1'b0, 2'd3);
        put_desc(32'h120, 32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, 2'd3);
        put_desc(32'h128, 32'h0000_5000, 20'h00010, 1'b0, 1'b1, 2'd0);
        put_desc(32'h208, 32'h0200_0000, 20'h000FF, 1'b0, 1'b1, 2'd3);

        repeat (3) @(negedge clk);
        // R8: reset state
        check(shadow_valid == 1'b0, "R8 valid after reset", 32'(shadow_valid), 32'd0);
        check(acc_fault == 2'b01, "R8 access before load", 32'(acc_fault), 32'd1);
        check(busy == 1'b0 && mem_req == 1'b0, "R4 idle after reset",
              32'({busy, mem_req}), 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            do_load(VECS[v].sel, VECS[v].cpl, int'(VECS[v].nrd),
                    $sformatf("R7 load %0d done", v));
            check(load_fault == VECS[v].lf, $sformatf("R6 R7 load fault vec %0d", v),
                  32'(load_fault), 32'(VECS[v].lf));
            check(n_xfer == int'(VECS[v].nrd), $sformatf("R2 R3 read count vec %0d", v),
                  32'(n_xfer), 32'(VECS[v].nrd));
            if (VECS[v].nrd != 0) begin
                exp_a = (VECS[v].sel[2] ? 32'h200 : 32'h100) + {16'h0, VECS[v].sel[15:3], 3'b000};
                check(xaddr[0] == exp_a, $sformatf("R1 low word address vec %0d", v),
                      xaddr[0], exp_a);
                check(xaddr[1] == exp_a + 32'd4, $sformatf("R4 high word address vec %0d", v),
                      xaddr[1], exp_a + 32'd4);
            end
            acc_off = VECS[v].off;
            #1;
            check(acc_fault == VECS[v].af, $sformatf("R9 access fault vec %0d", v),
                  32'(acc_fault), 32'(VECS[v].af));
            if (VECS[v].af == 2'b00)
                check(acc_lin == VECS[v].lin, $sformatf("R10 linear vec %0d", v),
                      acc_lin, VECS[v].lin);
        end

        // R5: cached attributes of a page-granular ring-3 entry and a byte-granular ring-0 entry
        do_load(16'h0013, 2'd3, 2, "R5 load done");
        check(seg_attr == 12'hCF2, "R5 attr ring3 page", 32'(seg_attr), 32'hCF2);
        do_load(16'h0008, 2'd0, 2, "R5 load done");
        check(seg_attr == 12'h492, "R5 attr ring0 byte", 32'(seg_attr), 32'h492);
        check(shadow_valid == 1'b1, "R8 valid after good load", 32'(shadow_valid), 32'd1);

        // R8: a faulting load invalidates an earlier good shadow
        do_load(16'h001B, 2'd3, 2, "R6 load done");
        check(shadow_valid == 1'b0, "R8 valid after fault", 32'(shadow_valid), 32'd0);
        acc_off = 32'h0;
        #1;
        check(acc_fault == 2'b01, "R8 access after fault", 32'(acc_fault), 32'd1);

        // R10: wrap at the top of the space, maximum offset
        do_load(16'h0023, 2'd3, 2, "R10 load done");
        acc_off = 32'hFFFF_FFFF;
        #1;
        check(acc_fault == 2'b00, "R9 max offset page granular", 32'(acc_fault), 32'd0);
        check(acc_lin == 32'hFFFF_EFFF, "R10 wrap max", acc_lin, 32'hFFFF_EFFF);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule